// File: doc/BRIEF.md
# Embedded Interval, Fixed-Period and Watchdog Timer Unit

This block gives a processor core three timers that run off an external time-base counter. The programmable interval timer counts down from a value that software loads. It decrements once for every clock cycle in which the time-base input changes. When it expires it either stops or reloads itself. The fixed-period timer raises a status flag each time a selectable bit of the time base changes value.

The watchdog also watches a selectable time-base bit. It escalates one stage at each change of that bit. The first change arms it, the second raises an interrupt, and the third copies the configured reset kind into the status register and requests that reset.

Software reaches a control register, a status register and the interval timer through a small register port. Status flags are cleared by writing ones to them. The block drives three level interrupt lines and three single-cycle reset request pulses, one each for core, chip and system. Each pulse is meant for a separate reset generator.

Top module: `etu_top`

## Requirements
- R1: After reset the control register, the status register, the interval count and the reload value are zero, and all six outputs are low.
- R2: The fixed-period event occurs in a cycle where bit 9+4*S of `tb_count` differs from its value in the previous cycle, with S taken from control bits 25:24. The event sets status bit 26. Changes of other time-base bits do not set it.
- R3: The interrupt outputs are registered one cycle behind the state they follow. `fit_irq` = status 26 AND control 23, `pit_irq` = status 27 AND control 26, and `wdt_irq` = status 30 AND control 27.
- R4: Writing address 1 clears each status bit among 31..26 whose written bit is 1 and leaves the bits written 0 unchanged. An event that sets a bit in the same cycle wins over the clear.
- R5: Writing address 2 stores the reload value and loads the count with it. The count decrements in every cycle where `tb_count` differs from the previous cycle. The step from 1 to 0 sets status bit 27. Without auto-reload the count then stays at 0.
- R6: With control bit 22 set, the expiring step loads the count from the reload value, so status 27 recurs every reload-value ticks.
- R7: A reload value of 0 or 1 leaves the count at 0, and status bit 27 is never set from it.
- R8: The watchdog event is a change of `tb_count` bit 17+4*W, with W from control bits 31:30. With status 31 clear, an event sets only status 31. With status 31 set and status 30 clear, an event sets status 30.
- R9: An event with status 31 and 30 both set copies control bits 29:28 into status bits 29:28. In the same cycle it raises, for one cycle, `rst_core_req` for code 1, `rst_chip_req` for code 2 or `rst_sys_req` for code 3. Code 0 raises no request.
- R10: `rd_data` is registered from `rd_addr`. Address 0 returns control bits 31:22 with zeros below them. Address 1 returns status bits 31:26 with zeros below them. Address 2 returns the current interval count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_count | input | TB_W | Free-running time-base value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 status, 2 interval |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 32 | Registered read data |
| fit_irq | output | 1 | Fixed-period interrupt, level |
| pit_irq | output | 1 | Interval timer interrupt, level |
| wdt_irq | output | 1 | Watchdog interrupt, level |
| rst_core_req | output | 1 | Core reset request pulse |
| rst_chip_req | output | 1 | Chip reset request pulse |
| rst_sys_req | output | 1 | System reset request pulse |

## Verification
The hardest state to reach is the third watchdog stage. In real time it needs three transitions of a high time-base bit, which would take millions of ticks. Because the time base is an input, the stimulus flips only the selected bit, so each watchdog event costs one cycle. Each escalation run draws a random reset code and checks both the copied code and the pulse. The interval timer is checked with random reload values and tick counts against a closed-form model of the count and the expiry flag.

// File: rtl/etu_pkg.sv
package etu_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_PIT  = 2'd2,
    REG_NONE = 2'd3
  } etu_reg_e;

  typedef enum logic [1:0] {
    RST_NONE = 2'd0,
    RST_CORE = 2'd1,
    RST_CHIP = 2'd2,
    RST_SYS  = 2'd3
  } etu_rst_e;

  // control register field positions
  localparam int C_WDP_HI = 31;
  localparam int C_WDP_LO = 30;
  localparam int C_WRS_HI = 29;
  localparam int C_WRS_LO = 28;
  localparam int C_WIE    = 27;
  localparam int C_PIE    = 26;
  localparam int C_FP_HI  = 25;
  localparam int C_FP_LO  = 24;
  localparam int C_FIE    = 23;
  localparam int C_ARE    = 22;
  localparam logic [31:0] CTRL_MASK = 32'hFFC0_0000;

  // status register field positions
  localparam int S_WEN    = 31;
  localparam int S_WIS    = 30;
  localparam int S_WRS_HI = 29;
  localparam int S_WRS_LO = 28;
  localparam int S_PIS    = 27;
  localparam int S_FIS    = 26;
endpackage

// File: rtl/etu_tb_tap.sv
module etu_tb_tap #(
  parameter int TB_W = 32,
  parameter int BASE = 9,
  parameter int STEP = 4
) (
  input  logic [TB_W-1:0] tb_now,
  input  logic [TB_W-1:0] tb_prev,
  input  logic            seen,
  input  logic [1:0]      sel,
  output logic            evt
);
  localparam int NSEL = 4;
  logic [NSEL-1:0] flip;

  for (genvar g = 0; g < NSEL; g++) begin : g_tap
    assign flip[g] = tb_now[BASE+STEP*g] ^ tb_prev[BASE+STEP*g];
  end

  assign evt = seen & flip[sel];
endmodule

// File: rtl/etu_interval.sv
module etu_interval #(
  parameter int PIT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PIT_W-1:0] load_val,
  input  logic             tick,
  input  logic             auto_en,
  input  logic             clr_st,
  output logic [PIT_W-1:0] count,
  output logic [PIT_W-1:0] reload,
  output logic             st
);
  localparam logic [PIT_W-1:0] ONE = PIT_W'(1);
  logic expire;

  assign expire = !load && tick && (count == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      reload <= '0;
      st     <= 1'b0;
    end else begin
      if (expire)      st <= 1'b1;
      else if (clr_st) st <= 1'b0;

      if (load) begin
        reload <= load_val;
        count  <= (load_val > ONE) ? load_val : '0;
      end else if (tick && count != '0) begin
        if (count == ONE) count <= auto_en ? reload : '0;
        else              count <= count - ONE;
      end
    end
  end
endmodule

// File: rtl/etu_watchdog.sv
module etu_watchdog
  import etu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       evt,
  input  logic [1:0] cfg_type,
  input  logic [3:0] clr_mask,
  output logic       en_st,
  output logic       int_st,
  output logic [1:0] type_st,
  output logic       rst_core,
  output logic       rst_chip,
  output logic       rst_sys
);
  logic       n_en, n_int, fire;
  logic [1:0] n_type;

  always_comb begin
    n_en   = en_st & ~clr_mask[3];
    n_int  = int_st & ~clr_mask[2];
    n_type = type_st & ~clr_mask[1:0];
    fire   = 1'b0;
    if (evt) begin
      if (!en_st)       n_en  = 1'b1;
      else if (!int_st) n_int = 1'b1;
      else begin
        n_type = cfg_type;
        fire   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_st    <= 1'b0;
      int_st   <= 1'b0;
      type_st  <= 2'b00;
      rst_core <= 1'b0;
      rst_chip <= 1'b0;
      rst_sys  <= 1'b0;
    end else begin
      en_st    <= n_en;
      int_st   <= n_int;
      type_st  <= n_type;
      rst_core <= fire && (cfg_type == RST_CORE);
      rst_chip <= fire && (cfg_type == RST_CHIP);
      rst_sys  <= fire && (cfg_type == RST_SYS);
    end
  end
endmodule

// File: rtl/etu_top.sv
module etu_top
  import etu_pkg::*;
#(
  parameter int TB_W     = 32,
  parameter int PIT_W    = 32,
  parameter int FIT_BASE = 9,
  parameter int FIT_STEP = 4,
  parameter int WDT_BASE = 17,
  parameter int WDT_STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TB_W-1:0] tb_count,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [31:0]     wr_data,
  input  logic [1:0]      rd_addr,
  output logic [31:0]     rd_data,
  output logic            fit_irq,
  output logic            pit_irq,
  output logic            wdt_irq,
  output logic            rst_core_req,
  output logic            rst_chip_req,
  output logic            rst_sys_req
);
  logic [31:0]      tcr;
  logic [TB_W-1:0]  tb_prev;
  logic             tb_seen;
  logic             tb_tick;
  logic             fit_evt, wdt_evt;
  logic             fit_st;
  logic             wr_ctrl, wr_stat, wr_pit;
  logic [PIT_W-1:0] pit_count, pit_reload;
  logic             pit_st;
  logic             wd_en_st, wd_int_st;
  logic [1:0]       wd_type_st;
  logic [31:0]      stat_word;

  assign wr_ctrl = wr_en && (wr_addr == REG_CTRL);
  assign wr_stat = wr_en && (wr_addr == REG_STAT);
  assign wr_pit  = wr_en && (wr_addr == REG_PIT);
  assign tb_tick = tb_seen && (tb_count != tb_prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      tb_prev <= '0;
      tb_seen <= 1'b0;
    end else begin
      tb_prev <= tb_count;
      tb_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          tcr <= '0;
    else if (wr_ctrl) tcr <= wr_data & CTRL_MASK;
  end

  etu_tb_tap #(.TB_W(TB_W), .BASE(FIT_BASE), .STEP(FIT_STEP)) u_fit_tap (
    .tb_now (tb_count),
    .tb_prev(tb_prev),
    .seen   (tb_seen),
    .sel    (tcr[C_FP_HI:C_FP_LO]),
    .evt    (fit_evt)
  );

  etu_tb_tap #(.TB_W(TB_W), .BASE(WDT_BASE), .STEP(WDT_STEP)) u_wdt_tap (
    .tb_now (tb_count),
    .tb_prev(tb_prev),
    .seen   (tb_seen),
    .sel    (tcr[C_WDP_HI:C_WDP_LO]),
    .evt    (wdt_evt)
  );

  always_ff @(posedge clk) begin
    if (rst)                               fit_st <= 1'b0;
    else if (fit_evt)                      fit_st <= 1'b1;
    else if (wr_stat && wr_data[S_FIS])    fit_st <= 1'b0;
  end

  etu_interval #(.PIT_W(PIT_W)) u_pit (
    .clk     (clk),
    .rst     (rst),
    .load    (wr_pit),
    .load_val(wr_data[PIT_W-1:0]),
    .tick    (tb_tick),
    .auto_en (tcr[C_ARE]),
    .clr_st  (wr_stat && wr_data[S_PIS]),
    .count   (pit_count),
    .reload  (pit_reload),
    .st      (pit_st)
  );

  etu_watchdog u_wdog (
    .clk     (clk),
    .rst     (rst),
    .evt     (wdt_evt),
    .cfg_type(tcr[C_WRS_HI:C_WRS_LO]),
    .clr_mask(wr_stat ? wr_data[S_WEN:S_WRS_LO] : 4'b0000),
    .en_st   (wd_en_st),
    .int_st  (wd_int_st),
    .type_st (wd_type_st),
    .rst_core(rst_core_req),
    .rst_chip(rst_chip_req),
    .rst_sys (rst_sys_req)
  );

  assign stat_word = {wd_en_st, wd_int_st, wd_type_st, pit_st, fit_st, 26'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      fit_irq <= 1'b0;
      pit_irq <= 1'b0;
      wdt_irq <= 1'b0;
      rd_data <= '0;
    end else begin
      fit_irq <= fit_st & tcr[C_FIE];
      pit_irq <= pit_st & tcr[C_PIE];
      wdt_irq <= wd_int_st & tcr[C_WIE];
      case (rd_addr)
        REG_CTRL: rd_data <= tcr;
        REG_STAT: rd_data <= stat_word;
        REG_PIT:  rd_data <= 32'(pit_count);
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/etu_checker.sv
module etu_checker #(
  parameter int PIT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             fit_irq,
  input logic             fit_st,
  input logic [31:0]      tcr,
  input logic             wr_pit,
  input logic [PIT_W-1:0] pit_count,
  input logic [PIT_W-1:0] pit_reload,
  input logic             wd_en_st,
  input logic             wd_int_st,
  input logic [1:0]       wd_type_st,
  input logic             rst_core_req,
  input logic             rst_chip_req,
  input logic             rst_sys_req
);
  logic rst_any;
  assign rst_any = rst_core_req | rst_chip_req | rst_sys_req;

  p_fit_irq_follow_r3: assert property (@(posedge clk) disable iff (rst)
    fit_irq == $past(fit_st && tcr[23]));

  p_count_bounded_r5: assert property (@(posedge clk) disable iff (rst)
    pit_count <= pit_reload);

  p_stopped_stays_r7: assert property (@(posedge clk) disable iff (rst)
    (pit_count == '0 && !wr_pit) |=> (pit_count == '0));

  p_int_after_arm_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_int_st) |-> $past(wd_en_st));

  p_pulse_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rst_core_req, rst_chip_req, rst_sys_req}));

  p_pulse_needs_stages_r9: assert property (@(posedge clk) disable iff (rst)
    rst_any |-> $past(wd_en_st && wd_int_st));

  p_chip_type_copied_r9: assert property (@(posedge clk) disable iff (rst)
    rst_chip_req |-> (wd_type_st == 2'd2));
endmodule

bind etu_top etu_checker #(.PIT_W(PIT_W)) u_etu_checker (
  .clk         (clk),
  .rst         (rst),
  .fit_irq     (fit_irq),
  .fit_st      (fit_st),
  .tcr         (tcr),
  .wr_pit      (wr_pit),
  .pit_count   (pit_count),
  .pit_reload  (pit_reload),
  .wd_en_st    (wd_en_st),
  .wd_int_st   (wd_int_st),
  .wd_type_st  (wd_type_st),
  .rst_core_req(rst_core_req),
  .rst_chip_req(rst_chip_req),
  .rst_sys_req (rst_sys_req)
);

// File: tb/etu_top_bench.sv
module etu_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] tb_count;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        fit_irq, pit_irq, wdt_irq;
  logic        rst_core_req, rst_chip_req, rst_sys_req;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  logic [31:0] tbv;

  always #(CLK_PERIOD/2) clk = ~clk;

  etu_top u_etu_top (
    .clk(clk), .rst(rst), .tb_count(tb_count),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .fit_irq(fit_irq), .pit_irq(pit_irq), .wdt_irq(wdt_irq),
    .rst_core_req(rst_core_req), .rst_chip_req(rst_chip_req),
    .rst_sys_req(rst_sys_req)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    step();
    d = rd_data;
  endtask

  task automatic set_tb(input logic [31:0] v);
    tbv = v;
    tb_count = v;
    step();
  endtask

  function automatic logic [31:0] exp_count(int r, bit a, int k);
    if (a) return 32'(r - (k % r));
    return (k < r) ? 32'(r - k) : 32'd0;
  endfunction

  function automatic logic [2:0] exp_pulse(int t);
    case (t)
      1: return 3'b100;
      2: return 3'b010;
      3: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    rst = 1'b1; tb_count = '0; tbv = '0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (3) step();
    rst = 1'b0;
    step();

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 32'h0);
    rd(2'd1, d); chk("R1 status", d, 32'h0);
    rd(2'd2, d); chk("R1 count", d, 32'h0);
    chk("R1 outputs", {26'b0, fit_irq, pit_irq, wdt_irq, rst_core_req, rst_chip_req, rst_sys_req}, 32'h0);

    // R10 control readback masks low bits
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R10 ctrl mask", d, 32'hFFC0_0000);
    wr(2'd0, 32'h0);

    // R2 fixed-period event, sel 0 -> bit 9, interrupt disabled
    set_tb(32'h0000_0200);
    rd(2'd1, d); chk("R2 fit status", d, 32'h0400_0000);
    step(); chk("R3 fit irq masked", {31'b0, fit_irq}, 32'h0);
    wr(2'd0, 32'h0080_0000);
    step(); step(); chk("R3 fit irq level", {31'b0, fit_irq}, 32'h1);
    // R4 zero write keeps, one write clears
    wr(2'd1, 32'h0);
    rd(2'd1, d); chk("R4 zero write keeps", d, 32'h0400_0000);
    wr(2'd1, 32'h0400_0000);
    rd(2'd1, d); chk("R4 w1c clears", d, 32'h0);
    step(); chk("R3 fit irq drops", {31'b0, fit_irq}, 32'h0);

    // R2 select 2 -> bit 17; bit 9 change ignored
    wr(2'd0, 32'h0200_0000);
    set_tb(32'h0000_0000);
    rd(2'd1, d); chk("R2 other bit ignored", d, 32'h0);
    set_tb(32'h0002_0000);
    rd(2'd1, d); chk("R2 sel2 event", d & 32'h0400_0000, 32'h0400_0000);
    wr(2'd1, 32'hFC00_0000);
    wr(2'd0, 32'h0);
    rd(2'd1, d); chk("R4 clear all", d, 32'h0);

    // R7 reload of 1 stays stopped
    wr(2'd2, 32'd1);
    for (int i = 0; i < 5; i++) set_tb(tbv + 1);
    rd(2'd2, d); chk("R7 count stays 0", d, 32'h0);
    rd(2'd1, d); chk("R7 no status", d & 32'h0800_0000, 32'h0);

    // R5 directed one-shot
    wr(2'd0, 32'h0400_0000);
    wr(2'd2, 32'd3);
    rd(2'd2, d); chk("R5 loaded", d, 32'd3);
    set_tb(tbv + 1);
    rd(2'd2, d); chk("R5 decrement", d, 32'd2);
    set_tb(tbv + 1); set_tb(tbv + 1);
    rd(2'd1, d); chk("R5 expiry status", d & 32'h0800_0000, 32'h0800_0000);
    chk("R3 pit irq", {31'b0, pit_irq}, 32'h1);
    set_tb(tbv + 1);
    rd(2'd2, d); chk("R5 stays zero", d, 32'h0);

    // R5/R6 random reloads and tick counts
    for (int it = 0; it < 24; it++) begin
      int r, k;
      bit a;
      r = 2 + int'($urandom % 11);
      k = 1 + int'($urandom % 30);
      a = $urandom % 2;
      wr(2'd0, a ? 32'h0440_0000 : 32'h0400_0000);
      wr(2'd1, 32'h0800_0000);
      wr(2'd2, 32'(r));
      for (int j = 0; j < k; j++) set_tb(tbv + 1);
      rd(2'd2, d);
      chk(a ? "R6 auto count" : "R5 oneshot count", d, exp_count(r, a, k));
      rd(2'd1, d);
      chk(a ? "R6 auto status" : "R5 oneshot status", d & 32'h0800_0000,
          (k >= r) ? 32'h0800_0000 : 32'h0);
    end
    wr(2'd2, 32'd0);
    wr(2'd1, 32'hFC00_0000);

    // R8 watchdog select 1 -> bit 21: bit 17 change ignored
    wr(2'd0, 32'h4000_0000);
    set_tb(tbv ^ 32'h0002_0000);
    rd(2'd1, d); chk("R8 wrong bit ignored", d & 32'hF000_0000, 32'h0);
    set_tb(tbv ^ 32'h0020_0000);
    rd(2'd1, d); chk("R8 sel1 arms", d & 32'hF000_0000, 32'h8000_0000);
    wr(2'd1, 32'hF000_0000);

    // R8/R9 random escalation runs, select 0 -> bit 17
    for (int it = 0; it < 12; it++) begin
      int t;
      t = int'($urandom % 4);
      wr(2'd1, 32'hF000_0000);
      wr(2'd0, 32'h0800_0000 | (32'(t) << 28));
      set_tb(tbv ^ 32'h0002_0000);
      rd(2'd1, d); chk("R8 stage one", d & 32'hF000_0000, 32'h8000_0000);
      chk("R3 wdt irq low", {31'b0, wdt_irq}, 32'h0);
      set_tb(tbv ^ 32'h0002_0000);
      rd(2'd1, d); chk("R8 stage two", d & 32'hF000_0000, 32'hC000_0000);
      chk("R3 wdt irq", {31'b0, wdt_irq}, 32'h1);
      set_tb(tbv ^ 32'h0002_0000);
      chk("R9 pulse", {29'b0, rst_core_req, rst_chip_req, rst_sys_req}, {29'b0, exp_pulse(t)});
      step();
      chk("R9 single cycle", {29'b0, rst_core_req, rst_chip_req, rst_sys_req}, 32'h0);
      rd(2'd1, d); chk("R9 type copied", d & 32'hF000_0000, 32'hC000_0000 | (32'(t) << 28));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule